// File: doc/BRIEF.md
# Packet-Filter VM Branch and PC Update Unit

This block resolves the control-flow instructions of a 64-bit packet-filter virtual machine and produces the program counter of the next instruction. The decoder supplies the current byte-address PC, the 3-bit instruction class, the 4-bit operation code, the operand-select bit, both register operands, the 32-bit immediate, the 16-bit signed offset and the register-number field. The unit evaluates the branch condition, forms the target, and registers the result one clock after the valid strobe.

Instructions occupy 8-byte slots. A branch offset counts slots from the instruction that follows the branch. Two compare classes exist: the 64-bit class compares whole operands, and the 32-bit class compares only the low halves. Subroutine entry and program termination are not resolved here. The unit reports them on one-cycle strobes and passes on the call displacement and register field, and the PC is left for the sequencer to redirect.

Top module: `vm_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, next_pc_o reads 0 and the taken, call, exit and illegal strobes read 0 until the first valid instruction.
- R2: For a valid instruction whose class is neither 3'b101 (64-bit jump) nor 3'b110 (32-bit jump), next_pc_o becomes pc+8, or pc+16 when wide_ld_i is 1, and no strobe is raised.
- R3: Operation code 0 (always) in a jump class is taken regardless of operands, and the target is pc + (sext(offset)+1)*8, with the offset signed over its full range and the result wrapping modulo 2^64.
- R4: A conditional jump whose condition is false gives next_pc_o = pc+8 with taken_o low.
- R5: Code 1 is taken on equality, code 5 on inequality, and code 4 when the bitwise AND of the operands is nonzero.
- R6: Codes 2 (>), 3 (>=), 10 (<) and 11 (<=) compare the operands as unsigned numbers.
- R7: Codes 6 (>), 7 (>=), 12 (<) and 13 (<=) compare the operands as two's-complement signed numbers.
- R8: In class 3'b110 only bits 31:0 of each operand take part in the comparison, and the signed codes use bit 31 as the sign. Class 3'b101 uses all 64 bits.
- R9: With src_sel_i = 0 the second comparand is imm_i sign-extended to 64 bits. With src_sel_i = 1 it is src_val_i, and imm_i is then ignored.
- R10: Code 8 in a jump class raises call_o for one cycle, presents imm_i on call_disp_o and src_fld_i on call_src_o, and sets next_pc_o to the instruction's own pc. wide_ld_i has no effect in a jump class.
- R11: Code 9 in a jump class raises exit_o for one cycle and sets next_pc_o to the instruction's own pc. At most one of taken_o, call_o, exit_o and illegal_o is high in any cycle.
- R12: Codes 14 and 15 in a jump class raise illegal_o for one cycle and set next_pc_o to the instruction's own pc.
- R13: In a cycle after valid_i was low, all four strobes are low and next_pc_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Instruction fields are valid this cycle |
| pc_i | input | 64 | Byte address of the current instruction |
| class_i | input | 3 | Instruction class (3'b101 64-bit jump, 3'b110 32-bit jump) |
| op_i | input | 4 | Operation code |
| src_sel_i | input | 1 | 0: immediate comparand, 1: register comparand |
| dst_val_i | input | 64 | Destination register value (first comparand) |
| src_val_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| off_i | input | 16 | Signed branch offset in slots |
| src_fld_i | input | 4 | Source register-number field |
| wide_ld_i | input | 1 | Current instruction is the two-slot wide load |
| next_pc_o | output | 64 | Registered next program counter |
| taken_o | output | 1 | Branch taken strobe |
| call_o | output | 1 | Call strobe |
| exit_o | output | 1 | Exit strobe |
| illegal_o | output | 1 | Undefined jump code strobe |
| call_disp_o | output | 32 | Displacement of the last call |
| call_src_o | output | 4 | Register field of the last call |

## Verification
Several operand pairs are chosen so that the unsigned and signed readings of the same bits give opposite results, for example all-ones against one. A wrong signedness on any relational code therefore changes the taken flag. Some operands differ only in their upper 32 bits, or carry a low half whose bit 31 is set, and these are run through both compare classes to separate full-width from low-half comparison and to expose a wrong sign bit. The bit-test code is driven once with disjoint masks and once with overlapping ones. Offsets of 0, -1, the largest positive and the most negative value check that the slot scaling counts from the following instruction and that the offset is sign-extended. Separate cases show that the register operand is used when src_sel_i is 1, that a negative immediate is sign-extended, and that the wide-load flag is ignored in a jump class.

// File: rtl/vbu_pkg.sv
package vbu_pkg;

  localparam logic [2:0] CLS_JMP64 = 3'b101;
  localparam logic [2:0] CLS_JMP32 = 3'b110;

  typedef enum logic [3:0] {
    BR_ALWAYS = 4'h0,
    BR_EQ     = 4'h1,
    BR_UGT    = 4'h2,
    BR_UGE    = 4'h3,
    BR_TEST   = 4'h4,
    BR_NE     = 4'h5,
    BR_SGT    = 4'h6,
    BR_SGE    = 4'h7,
    BR_CALL   = 4'h8,
    BR_EXIT   = 4'h9,
    BR_ULT    = 4'hA,
    BR_ULE    = 4'hB,
    BR_SLT    = 4'hC,
    BR_SLE    = 4'hD,
    BR_RSV_E  = 4'hE,
    BR_RSV_F  = 4'hF
  } br_op_e;

  typedef struct packed {
    logic taken;
    logic call;
    logic exit;
    logic illegal;
  } br_flags_t;

endpackage

// File: rtl/vbu_cmp.sv
module vbu_cmp
  import vbu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic            narrow_i,
  input  br_op_e          op_i,
  input  logic [XLEN-1:0] lhs_i,
  input  logic [XLEN-1:0] rhs_i,
  output logic            hit_o
);

  localparam int PADW = XLEN - NARROW;

  logic [XLEN-1:0] ua, ub, sa, sb;
  logic eq, ugt, ult, sgt, slt, anyb;

  always_comb begin
    if (narrow_i) begin
      ua = {{PADW{1'b0}}, lhs_i[NARROW-1:0]};
      ub = {{PADW{1'b0}}, rhs_i[NARROW-1:0]};
      sa = {{PADW{lhs_i[NARROW-1]}}, lhs_i[NARROW-1:0]};
      sb = {{PADW{rhs_i[NARROW-1]}}, rhs_i[NARROW-1:0]};
    end else begin
      ua = lhs_i;
      ub = rhs_i;
      sa = lhs_i;
      sb = rhs_i;
    end
  end

  assign eq   = (ua == ub);
  assign ugt  = (ua > ub);
  assign ult  = (ua < ub);
  assign sgt  = ($signed(sa) > $signed(sb));
  assign slt  = ($signed(sa) < $signed(sb));
  assign anyb = |(ua & ub);

  always_comb begin
    unique case (op_i)
      BR_ALWAYS: hit_o = 1'b1;
      BR_EQ:     hit_o = eq;
      BR_NE:     hit_o = !eq;
      BR_TEST:   hit_o = anyb;
      BR_UGT:    hit_o = ugt;
      BR_UGE:    hit_o = !ult;
      BR_ULT:    hit_o = ult;
      BR_ULE:    hit_o = !ugt;
      BR_SGT:    hit_o = sgt;
      BR_SGE:    hit_o = !slt;
      BR_SLT:    hit_o = slt;
      BR_SLE:    hit_o = !sgt;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vbu_tgt.sv
module vbu_tgt #(
  parameter int XLEN       = 64,
  parameter int OFFW       = 16,
  parameter int SLOT_BYTES = 8
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [OFFW-1:0] off_i,
  output logic [XLEN-1:0] step1_o,
  output logic [XLEN-1:0] step2_o,
  output logic [XLEN-1:0] jump_o
);

  localparam int SLOT_SH = $clog2(SLOT_BYTES);
  localparam logic [XLEN-1:0] ONE_SLOT = XLEN'(SLOT_BYTES);
  localparam logic [XLEN-1:0] TWO_SLOT = XLEN'(2 * SLOT_BYTES);

  logic [XLEN-1:0] off_x;
  logic [XLEN-1:0] slots;

  assign off_x   = {{(XLEN-OFFW){off_i[OFFW-1]}}, off_i};
  assign slots   = off_x + XLEN'(1);
  assign step1_o = pc_i + ONE_SLOT;
  assign step2_o = pc_i + TWO_SLOT;
  assign jump_o  = pc_i + (slots << SLOT_SH);

endmodule

// File: rtl/vm_branch_unit.sv
module vm_branch_unit
  import vbu_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NARROW     = 32,
  parameter int IMMW       = 32,
  parameter int OFFW       = 16,
  parameter int REGW       = 4,
  parameter int SLOT_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [2:0]      class_i,
  input  logic [3:0]      op_i,
  input  logic            src_sel_i,
  input  logic [XLEN-1:0] dst_val_i,
  input  logic [XLEN-1:0] src_val_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [REGW-1:0] src_fld_i,
  input  logic            wide_ld_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            call_o,
  output logic            exit_o,
  output logic            illegal_o,
  output logic [IMMW-1:0] call_disp_o,
  output logic [REGW-1:0] call_src_o
);

  localparam logic [XLEN-1:0] ONE_SLOT = XLEN'(SLOT_BYTES);
  localparam logic [XLEN-1:0] TWO_SLOT = XLEN'(2 * SLOT_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // decode
  br_op_e          op;
  logic            jump_cls;
  logic            narrow;
  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] rhs;
  logic            hit;
  logic [XLEN-1:0] step1, step2, jpc;

  assign op       = br_op_e'(op_i);
  assign narrow   = (class_i == CLS_JMP32);
  assign jump_cls = (class_i == CLS_JMP64) || narrow;
  assign imm_x    = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
  assign rhs      = src_sel_i ? src_val_i : imm_x;

  vbu_cmp #(.XLEN(XLEN), .NARROW(NARROW)) u_cmp (
    .narrow_i (narrow),
    .op_i     (op),
    .lhs_i    (dst_val_i),
    .rhs_i    (rhs),
    .hit_o    (hit)
  );

  vbu_tgt #(.XLEN(XLEN), .OFFW(OFFW), .SLOT_BYTES(SLOT_BYTES)) u_tgt (
    .pc_i    (pc_i),
    .off_i   (off_i),
    .step1_o (step1),
    .step2_o (step2),
    .jump_o  (jpc)
  );

  // next state
  logic [XLEN-1:0] pc_d, pc_q;
  br_flags_t       fl_d, fl_q;
  logic [IMMW-1:0] disp_d, disp_q;
  logic [REGW-1:0] srcf_d, srcf_q;

  always_comb begin
    pc_d   = pc_q;
    fl_d   = '0;
    disp_d = disp_q;
    srcf_d = srcf_q;
    if (valid_i) begin
      if (!jump_cls) begin
        pc_d = wide_ld_i ? step2 : step1;
      end else begin
        unique case (op)
          BR_CALL: begin
            pc_d    = pc_i;
            fl_d.call = 1'b1;
            disp_d  = imm_i;
            srcf_d  = src_fld_i;
          end
          BR_EXIT: begin
            pc_d      = pc_i;
            fl_d.exit = 1'b1;
          end
          BR_RSV_E, BR_RSV_F: begin
            pc_d         = pc_i;
            fl_d.illegal = 1'b1;
          end
          default: begin
            fl_d.taken = hit;
            pc_d       = hit ? jpc : step1;
          end
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q   <= '0;
      fl_q   <= '0;
      disp_q <= '0;
      srcf_q <= '0;
    end else begin
      fl_q <= fl_d;
      if (valid_i) begin
        pc_q   <= pc_d;
        disp_q <= disp_d;
        srcf_q <= srcf_d;
      end
    end
  end

  assign next_pc_o   = pc_q;
  assign taken_o     = fl_q.taken;
  assign call_o      = fl_q.call;
  assign exit_o      = fl_q.exit;
  assign illegal_o   = fl_q.illegal;
  assign call_disp_o = disp_q;
  assign call_src_o  = srcf_q;

  // checks
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !valid_i |=> (!taken_o && !call_o && !exit_o && !illegal_o && $stable(next_pc_o)));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_i && !jump_cls) |=>
      (next_pc_o == $past(pc_i) + ($past(wide_ld_i) ? TWO_SLOT : ONE_SLOT)) && !taken_o);

  // R3
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_i && jump_cls && op_i == 4'h0) |=> taken_o);

  // R10
  call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_i && jump_cls && op_i == 4'h8) |=>
      (call_o && next_pc_o == $past(pc_i) && call_disp_o == $past(imm_i)));

  // R12
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_i && jump_cls && op_i >= 4'hE) |=> (illegal_o && next_pc_o == $past(pc_i)));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({taken_o, call_o, exit_o, illegal_o}));

endmodule

// File: tb/vm_branch_unit_bench.sv
module vm_branch_unit_bench;

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  op;
    logic        sel;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] imm;
    logic [15:0] off;
    logic        wide;
    logic [63:0] xpc;
    logic [3:0]  xfl;   // {taken, call, exit, illegal}
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] P  = 64'h1000;
  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 29;

  localparam vec_t VEC [NV] = '{
    // R2 non-jump class
    '{3'd0, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 1'b0, 64'h1008, 4'b0000, 4'd2},
    '{3'd0, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 1'b1, 64'h1010, 4'b0000, 4'd2},
    // R3 always, offsets
    '{3'd5, 4'h0, 1'b0, 64'd1, 64'd2, 32'd3, 16'd2, 1'b0, 64'h1018, 4'b1000, 4'd3},
    '{3'd5, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'hFFFF, 1'b0, 64'h1000, 4'b1000, 4'd3},
    // R5 equality, inequality, bit test
    '{3'd5, 4'h1, 1'b0, 64'd5, 64'd0, 32'd5, 16'd3, 1'b0, 64'h1020, 4'b1000, 4'd5},
    '{3'd5, 4'h1, 1'b0, 64'd6, 64'd0, 32'd5, 16'd3, 1'b0, 64'h1008, 4'b0000, 4'd4},
    '{3'd5, 4'h5, 1'b1, 64'd1, 64'd2, 32'd0, 16'd0, 1'b0, 64'h1008, 4'b1000, 4'd5},
    '{3'd5, 4'h4, 1'b0, 64'hF0, 64'd0, 32'h0F, 16'd1, 1'b0, 64'h1008, 4'b0000, 4'd5},
    '{3'd5, 4'h4, 1'b0, 64'hF0, 64'd0, 32'h10, 16'd1, 1'b0, 64'h1010, 4'b1000, 4'd5},
    // R6 / R7 signedness
    '{3'd5, 4'h2, 1'b1, M1, 64'd1, 32'd0, 16'd4, 1'b0, 64'h1028, 4'b1000, 4'd6},
    '{3'd5, 4'h6, 1'b1, M1, 64'd1, 32'd0, 16'd4, 1'b0, 64'h1008, 4'b0000, 4'd7},
    '{3'd5, 4'hA, 1'b0, 64'd1, 64'd0, 32'hFFFF_FFFF, 16'd1, 1'b0, 64'h1010, 4'b1000, 4'd9},
    '{3'd5, 4'hC, 1'b0, 64'd1, 64'd0, 32'hFFFF_FFFF, 16'd1, 1'b0, 64'h1008, 4'b0000, 4'd7},
    '{3'd5, 4'h3, 1'b1, 64'd7, 64'd7, 32'd0, 16'd1, 1'b0, 64'h1010, 4'b1000, 4'd6},
    '{3'd5, 4'hB, 1'b1, 64'd8, 64'd7, 32'd0, 16'd1, 1'b0, 64'h1008, 4'b0000, 4'd6},
    '{3'd5, 4'h7, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 32'd0, 16'd1, 1'b0, 64'h1010, 4'b1000, 4'd7},
    '{3'd5, 4'hD, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 32'hFFFF_FFFE, 16'd1, 1'b0, 64'h1010, 4'b1000, 4'd7},
    // R8 narrow class
    '{3'd6, 4'h1, 1'b1, 64'hAAAA_0000_0000_0005, 64'd5, 32'd0, 16'd2, 1'b0, 64'h1018, 4'b1000, 4'd8},
    '{3'd5, 4'h1, 1'b1, 64'hAAAA_0000_0000_0005, 64'd5, 32'd0, 16'd2, 1'b0, 64'h1008, 4'b0000, 4'd8},
    '{3'd6, 4'h6, 1'b0, 64'h0000_0001_8000_0000, 64'd0, 32'd0, 16'd1, 1'b0, 64'h1008, 4'b0000, 4'd8},
    '{3'd6, 4'h2, 1'b0, 64'h0000_0001_8000_0000, 64'd0, 32'd0, 16'd1, 1'b0, 64'h1010, 4'b1000, 4'd8},
    // R3 extreme offsets
    '{3'd5, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'h7FFF, 1'b0, 64'h41000, 4'b1000, 4'd3},
    '{3'd5, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'h8000, 1'b0, 64'hFFFF_FFFF_FFFC_1008, 4'b1000, 4'd3},
    // R10 call, R11 exit, R12 illegal
    '{3'd5, 4'h8, 1'b0, 64'd0, 64'd0, 32'h1234_5678, 16'd0, 1'b1, 64'h1000, 4'b0100, 4'd10},
    '{3'd5, 4'h9, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 1'b0, 64'h1000, 4'b0010, 4'd11},
    '{3'd5, 4'hE, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 1'b0, 64'h1000, 4'b0001, 4'd12},
    '{3'd6, 4'hF, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 1'b0, 64'h1000, 4'b0001, 4'd12},
    // R4 narrow unsigned false, R9 register operand wins over imm
    '{3'd6, 4'hA, 1'b1, 64'd5, 64'h1_0000_0000, 32'd9, 16'd1, 1'b0, 64'h1008, 4'b0000, 4'd4},
    '{3'd5, 4'h1, 1'b1, 64'd5, 64'd9, 32'd5, 16'd1, 1'b0, 64'h1008, 4'b0000, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [63:0] pc_i;
  logic [2:0]  class_i;
  logic [3:0]  op_i;
  logic        src_sel_i;
  logic [63:0] dst_val_i, src_val_i;
  logic [31:0] imm_i;
  logic [15:0] off_i;
  logic [3:0]  src_fld_i;
  logic        wide_ld_i;
  logic [63:0] next_pc_o;
  logic        taken_o, call_o, exit_o, illegal_o;
  logic [31:0] call_disp_o;
  logic [3:0]  call_src_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vm_branch_unit u_vm_branch_unit (
    .clk, .rst_n, .valid_i, .pc_i, .class_i, .op_i, .src_sel_i,
    .dst_val_i, .src_val_i, .imm_i, .off_i, .src_fld_i, .wide_ld_i,
    .next_pc_o, .taken_o, .call_o, .exit_o, .illegal_o,
    .call_disp_o, .call_src_o
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {taken_o, call_o, exit_o, illegal_o};
  endfunction

  task automatic idle();
    valid_i = 1'b0;
    class_i = 3'd5;
    op_i    = 4'h0;
    pc_i    = 64'hDEAD_0000;
    off_i   = 16'd7;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    src_sel_i = 1'b0; dst_val_i = '0; src_val_i = '0; imm_i = '0;
    src_fld_i = '0; wide_ld_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check64("R1 next_pc in reset", next_pc_o, 64'd0);
    check64("R1 strobes in reset", {60'd0, flags()}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check64("R1 next_pc after release", next_pc_o, 64'd0);
    check64("R1 strobes after release", {60'd0, flags()}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      valid_i   = 1'b1;
      pc_i      = P;
      class_i   = VEC[i].cls;
      op_i      = VEC[i].op;
      src_sel_i = VEC[i].sel;
      dst_val_i = VEC[i].dst;
      src_val_i = VEC[i].src;
      imm_i     = VEC[i].imm;
      off_i     = VEC[i].off;
      wide_ld_i = VEC[i].wide;
      src_fld_i = 4'(i);
      @(negedge clk);
      check64($sformatf("R%0d vec %0d next_pc", VEC[i].req, i), next_pc_o, VEC[i].xpc);
      check64($sformatf("R%0d vec %0d flags", VEC[i].req, i), {60'd0, flags()}, {60'd0, VEC[i].xfl});
    end

    // R10 call payload and wide flag ignored in jump class
    valid_i = 1'b1; pc_i = 64'h2000; class_i = 3'd6; op_i = 4'h8;
    imm_i = 32'hCAFE_0042; src_fld_i = 4'hB; wide_ld_i = 1'b1;
    @(negedge clk);
    check64("R10 call_disp", {32'd0, call_disp_o}, 64'hCAFE_0042);
    check64("R10 call_src", {60'd0, call_src_o}, 64'hB);
    check64("R10 call pc held", next_pc_o, 64'h2000);
    check64("R10 call strobe", {60'd0, flags()}, 64'b0100);

    // R13 idle: strobes fall, pc holds despite changing inputs
    idle();
    @(negedge clk);
    check64("R13 idle strobes", {60'd0, flags()}, 64'd0);
    check64("R13 idle pc hold", next_pc_o, 64'h2000);
    @(negedge clk);
    check64("R13 idle pc hold 2", next_pc_o, 64'h2000);

    // R11 exit strobe lasts one cycle
    valid_i = 1'b1; pc_i = 64'h3000; class_i = 3'd5; op_i = 4'h9;
    @(negedge clk);
    idle();
    @(negedge clk);
    check64("R11 exit one cycle", {60'd0, flags()}, 64'd0);
    check64("R11 exit pc", next_pc_o, 64'h3000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule